// File: doc/BRIEF.md
# Round-Robin Replicated Slow-Stage Pipeline

This block is a three-stage streaming pipeline whose middle stage needs several clock cycles to finish one job. The slow stage is not allowed to set the pace. It is built as `COPIES` identical worker copies, and the jobs are handed out to those copies in strict rotation. A fresh job can therefore enter on every clock, and one result leaves on every clock once the pipeline is full.

The front stage takes a valid/data pair, applies a one-cycle placeholder operation (add one) and registers the result. The rotating dispatcher loads that value into the next copy in turn. The copy holds the operand and accumulates it once per cycle for `COPIES` cycles, which gives `COPIES * x`. The back stage picks whichever copy has just finished, applies an XOR with a fixed mask taken from the low bits of `64'hA5C35A3C96E11E69`, and registers the valid, the data and the index of the copy that did the work. There is no stall path: the input is never refused.

Top module: `interleaved_slow_pipe`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_vld` is 0 and `out_slot` is 0.
- R2: For a job with input data `d`, `out_dat` equals `((d + 1) * COPIES) XOR mask`, truncated to `DATA_W` bits. The mask is the low `DATA_W` bits of `64'hA5C35A3C96E11E69` (8'h69 for `DATA_W`=8).
- R3: A job sampled with `in_vld` high at rising edge t is presented with `out_vld` high after edge t+COPIES+1, which is five cycles in all for `COPIES`=3. This holds for every job and does not depend on the jobs around it.
- R4: With `in_vld` held high on consecutive cycles, the outputs show a matching unbroken run of consecutive valid cycles, so the block sustains one result per clock.
- R5: Results leave in exactly the order in which the jobs entered.
- R6: The n-th job accepted since reset (counting from 0) is processed by copy n mod COPIES, and `out_slot` reports that copy index. Cycles with `in_vld` low do not advance the rotation.
- R7: A cycle with `in_vld` low produces no output: `COPIES+1` edges later `out_vld` is low.
- R8: Each copy is busy for exactly `COPIES` cycles per job, at most one copy completes in any cycle, and a copy is never reloaded while it still holds an unfinished job.
- R9: Asserting reset in the middle of a stream discards every job in flight, and the first job after reset goes to copy 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | 1 | A job is present on `in_dat` this cycle |
| in_dat | input | DATA_W | Job operand |
| out_vld | output | 1 | A finished result is present this cycle |
| out_dat | output | DATA_W | Result of the three stages |
| out_slot | output | SLOT_W | Index of the slow-stage copy that produced the result |

## Verification
The bench builds the block with `DATA_W`=8 and `COPIES`=3. With 8-bit data, an unbroken back-to-back run covers every one of the 256 input values, so the arithmetic of all three stages is checked completely, and the mask and multiply wrap is exercised at the top of the range. Keeping three copies makes the rotation short. The alternating, sparse, pseudo-random and every-third-cycle valid patterns therefore reach every phase of the rotation against every gap length, and a mid-stream reset lands with all copies busy.

// File: rtl/isp_pkg.sv
package isp_pkg;
  // Mask source for the back-stage placeholder operation (low bits are used).
  localparam logic [63:0] BACK_MASK = 64'hA5C3_5A3C_96E1_1E69;

  // Width needed to count 0..n inclusive.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Width needed to index n items.
  function automatic int idx_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/isp_front.sv
module isp_front #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_dat,
  output logic              s1_vld,
  output logic [DATA_W-1:0] s1_dat
);
  logic              vld_d;
  logic [DATA_W-1:0] dat_d;

  always_comb begin
    vld_d = in_vld;
    dat_d = in_dat + DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_vld <= 1'b0;
    else        s1_vld <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (in_vld) s1_dat <= dat_d;
  end
endmodule

// File: rtl/isp_rr_dispatch.sv
module isp_rr_dispatch #(
  parameter int COPIES = 3,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              job_vld,
  output logic [COPIES-1:0] load_vec
);
  logic [SLOT_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (job_vld) begin
      if (ptr_q == SLOT_W'(COPIES - 1)) ptr_d = '0;
      else                              ptr_d = ptr_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (job_vld) ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < COPIES; g++) begin : g_load
    assign load_vec[g] = job_vld && (ptr_q == SLOT_W'(g));
  end
endmodule

// File: rtl/isp_copy.sv
module isp_copy #(
  parameter int DATA_W = 16,
  parameter int COPIES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] opnd_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  localparam int CNT_W = isp_pkg::cnt_width(COPIES);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] opnd_q, opnd_d, acc_q, acc_d;
  logic              en;
  logic              last;

  assign last = busy_q && (cnt_q == CNT_W'(COPIES));
  assign en   = load || busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    opnd_d = opnd_q;
    acc_d  = acc_q;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(1);
      opnd_d = opnd_in;
      acc_d  = opnd_in;
    end else if (last) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q + CNT_W'(1);
      acc_d = acc_q + opnd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      opnd_q <= opnd_d;
      acc_q  <= acc_d;
    end
  end

  assign busy   = busy_q;
  assign done   = last;
  assign result = acc_q;
endmodule

// File: rtl/isp_merge.sv
module isp_merge #(
  parameter int DATA_W = 16,
  parameter int COPIES = 3,
  parameter int SLOT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [COPIES-1:0]        done_vec,
  input  logic [COPIES*DATA_W-1:0] res_flat,
  output logic                     out_vld,
  output logic [DATA_W-1:0]        out_dat,
  output logic [SLOT_W-1:0]        out_slot
);
  localparam logic [DATA_W-1:0] MASK = isp_pkg::BACK_MASK[DATA_W-1:0];

  logic              any_done;
  logic [DATA_W-1:0] sel_dat;
  logic [SLOT_W-1:0] sel_slot;

  always_comb begin
    sel_dat  = '0;
    sel_slot = '0;
    for (int i = 0; i < COPIES; i++) begin
      if (done_vec[i]) begin
        sel_dat  = sel_dat  | res_flat[i*DATA_W +: DATA_W];
        sel_slot = sel_slot | SLOT_W'(i);
      end
    end
    any_done = |done_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_slot <= '0;
    end else begin
      out_vld <= any_done;
      if (any_done) out_slot <= sel_slot;
    end
  end

  always_ff @(posedge clk) begin
    if (any_done) out_dat <= sel_dat ^ MASK;
  end
endmodule

// File: rtl/interleaved_slow_pipe.sv
module interleaved_slow_pipe #(
  parameter int DATA_W = 16,
  parameter int COPIES = 3,
  parameter int SLOT_W = isp_pkg::idx_width(COPIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_dat,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_dat,
  output logic [SLOT_W-1:0] out_slot
);
  logic                     s1_vld;
  logic [DATA_W-1:0]        s1_dat;
  logic [COPIES-1:0]        load_vec;
  logic [COPIES-1:0]        busy_vec;
  logic [COPIES-1:0]        done_vec;
  logic [COPIES*DATA_W-1:0] res_flat;

  isp_front #(.DATA_W(DATA_W)) front_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dat(in_dat),
    .s1_vld(s1_vld), .s1_dat(s1_dat)
  );

  isp_rr_dispatch #(.COPIES(COPIES), .SLOT_W(SLOT_W)) disp_i (
    .clk(clk), .rst_n(rst_n), .job_vld(s1_vld), .load_vec(load_vec)
  );

  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    isp_copy #(.DATA_W(DATA_W), .COPIES(COPIES)) copy_i (
      .clk(clk), .rst_n(rst_n), .load(load_vec[g]), .opnd_in(s1_dat),
      .busy(busy_vec[g]), .done(done_vec[g]),
      .result(res_flat[g*DATA_W +: DATA_W])
    );
  end

  isp_merge #(.DATA_W(DATA_W), .COPIES(COPIES), .SLOT_W(SLOT_W)) merge_i (
    .clk(clk), .rst_n(rst_n), .done_vec(done_vec), .res_flat(res_flat),
    .out_vld(out_vld), .out_dat(out_dat), .out_slot(out_slot)
  );
endmodule

// File: rtl/isp_checker.sv
module isp_checker #(
  parameter int COPIES = 3,
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s1_vld,
  input logic              out_vld,
  input logic [SLOT_W-1:0] out_slot,
  input logic [COPIES-1:0] load_vec,
  input logic [COPIES-1:0] busy_vec,
  input logic [COPIES-1:0] done_vec
);
  // R1: outputs idle while reset is held
  always @(posedge clk) begin
    if (!rst_n) p_idle_in_reset_r1: assert (!out_vld && out_slot == '0);
  end

  // R8: no two copies finish in the same cycle
  p_single_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_vec));

  // R6: a job leaving stage 1 lands in exactly one copy
  p_one_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> $onehot(load_vec));

  // R3: a finishing copy yields a valid output on the next cycle
  p_finish_to_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_vec) |=> out_vld);

  // R7: no output without a copy having finished the cycle before
  p_no_spurious_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(|done_vec));

  // R6: consecutive results come from consecutive copies
  p_rotation_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(out_vld)) |->
      (out_slot == (($past(out_slot) == SLOT_W'(COPIES - 1)) ? '0 : $past(out_slot) + SLOT_W'(1))));

  for (genvar g = 0; g < COPIES; g++) begin : g_copy_chk
    // R8: a copy is never reloaded while holding an unfinished job
    p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load_vec[g] |-> (!busy_vec[g] || done_vec[g]));
    // R8: a finishing copy was already busy on the previous cycle
    p_busy_before_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_vec[g] |-> $past(busy_vec[g]));
  end
endmodule

bind interleaved_slow_pipe isp_checker #(.COPIES(COPIES), .SLOT_W(SLOT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .s1_vld(s1_vld), .out_vld(out_vld),
  .out_slot(out_slot), .load_vec(load_vec), .busy_vec(busy_vec),
  .done_vec(done_vec)
);

// File: tb/interleaved_slow_pipe_tb_top.sv
`timescale 1ns/1ps
module interleaved_slow_pipe_tb_top;
  localparam int DW   = 8;
  localparam int NC   = 3;
  localparam int SW   = 2;
  localparam int LAT  = NC + 2;   // negedge drive index to negedge observe index
  localparam int NMAX = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_vld = 1'b0;
  logic [DW-1:0] in_dat = '0;
  logic          out_vld;
  logic [DW-1:0] out_dat;
  logic [SW-1:0] out_slot;

  always #4 clk = ~clk;

  interleaved_slow_pipe #(.DATA_W(DW), .COPIES(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dat(in_dat),
    .out_vld(out_vld), .out_dat(out_dat), .out_slot(out_slot)
  );

  int checks = 0;
  int fails  = 0;
  int k      = 0;
  int njobs  = 0;
  int obs_cnt = 0;
  int run_len = 0;
  int run_max = 0;
  bit finished = 1'b0;

  logic          exp_v [NMAX];
  logic [DW-1:0] exp_d [NMAX];
  logic [SW-1:0] exp_s [NMAX];

  function automatic logic [DW-1:0] model(input logic [DW-1:0] d);
    logic [DW-1:0] a;
    a = d + DW'(1);
    return DW'(a * NC) ^ 8'h69;
  endfunction

  task automatic check_now();
    checks++;
    if (out_vld !== exp_v[k]) begin
      fails++;
      $display("FAIL R3 R7 cycle %0d: out_vld=%b expected %b", k, out_vld, exp_v[k]);
    end
    if (out_vld === 1'b1) begin
      obs_cnt++; run_len++;
      if (run_len > run_max) run_max = run_len;
    end else run_len = 0;
    if (exp_v[k] === 1'b1) begin
      checks++;
      if (out_dat !== exp_d[k]) begin
        fails++;
        $display("FAIL R2 R5 cycle %0d: out_dat=%h expected %h", k, out_dat, exp_d[k]);
      end
      checks++;
      if (out_slot !== exp_s[k]) begin
        fails++;
        $display("FAIL R6 R9 cycle %0d: out_slot=%0d expected %0d", k, out_slot, exp_s[k]);
      end
    end
  endtask

  task automatic step(input logic v, input logic [DW-1:0] d);
    @(negedge clk);
    k++;
    check_now();
    in_vld = v;
    in_dat = d;
    if (v) begin
      exp_v[k+LAT] = 1'b1;
      exp_d[k+LAT] = model(d);
      exp_s[k+LAT] = SW'(njobs % NC);
      njobs++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    k++;
    check_now();
    rst_n  = 1'b0;
    in_vld = 1'b0;
    for (int i = k + 1; i < NMAX; i++) exp_v[i] = 1'b0;
    njobs = 0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      k++;
      checks++;
      if (out_vld !== 1'b0 || out_slot !== '0) begin
        fails++;
        $display("FAIL R1 R9 in reset: vld=%b slot=%0d expected 0 0", out_vld, out_slot);
      end
    end
    rst_n = 1'b1;
  endtask

  initial begin
    int c0;
    logic [15:0] lfsr;
    for (int i = 0; i < NMAX; i++) exp_v[i] = 1'b0;
    do_reset();
    @(negedge clk);
    k++;
    checks++;
    if (out_vld !== 1'b0 || out_slot !== '0) begin
      fails++;
      $display("FAIL R1 after reset: vld=%b slot=%0d expected 0 0", out_vld, out_slot);
    end
    check_now();

    // Back-to-back sweep of every data value (R2 R4 R8)
    c0 = obs_cnt; run_max = 0;
    for (int i = 0; i < 256; i++) step(1'b1, DW'(i));
    for (int i = 0; i < LAT + 1; i++) step(1'b0, '0);
    checks++;
    if (obs_cnt - c0 != 256 || run_max < 256) begin
      fails++;
      $display("FAIL R4 R8 throughput: results=%0d run=%0d expected 256 256", obs_cnt - c0, run_max);
    end

    // Alternating valid, descending data (R5 R6 R7)
    for (int i = 0; i < 256; i++) step(i[0], DW'(255 - i));
    // Every third cycle: rotation advances only on jobs (R6)
    for (int i = 0; i < 90; i++) step((i % 3) == 0, DW'(i * 7));
    // Sparse groups with long gaps
    for (int i = 0; i < 80; i++) step((i % 8) < 2, DW'(i * 13 + 5));
    // Pseudo-random valid pattern (R3 R5 R7)
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], lfsr[15:8]);
    end
    // Mid-stream reset with all copies busy (R9)
    for (int i = 0; i < 5; i++) step(1'b1, DW'(i + 40));
    do_reset();
    step(1'b1, 8'hFF);
    step(1'b0, '0);
    step(1'b1, 8'h10);
    for (int i = 0; i < LAT + 3; i++) step(1'b0, '0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule